// File: doc/BRIEF.md
# Eight-bit PWM waveform timer

This block is an 8-bit timer/counter with a waveform output. A single system clock runs all of its logic. The counter advances only on a clock-enable tick, and a prescaler makes that tick at one of five division ratios. A 3-bit waveform-generation field picks the count sequence and the waveform type:

- free-running count
- clear on compare match
- fast (single-slope) PWM
- phase-correct (dual-slope) PWM

A 2-bit output-mode field sets what the compare output does. In the PWM modes it also selects inverted or non-inverted output. The block raises a one-cycle overflow pulse and a one-cycle compare pulse, and it exposes the live count.

Software programs the block through a plain register write port. Each write selects one of four registers by address:

| Address | Register |
|---|---|
| 0 | waveform mode |
| 1 | compare value |
| 2 | output mode |
| 3 | prescale select |

A write lands on the clock edge at which `cfg_we` is high. No data stream crosses the block's edge, so it has no valid/ready handshake. Every pin is a plain control or status signal. `wave_en` tells the surrounding pin logic when the waveform should take over the pin.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count is 0, `wave_out`, `wave_en`, `ovf_flag` and `cmp_flag` are 0, and the prescale select is 0, so the counter is stopped.
- R2: The prescale select codes are 0 = stopped, 1 = every clock, 2 = every 8th clock, 3 = every 64th, 4 = every 256th and 5 = every 1024th. Codes 6 and 7 stop the counter. The count changes only on a tick.
- R3: The waveform mode codes are 0 = free-running, 1 = phase-correct PWM, 2 = clear on match and 3 = fast PWM. Codes 4 to 7 behave as code 0. In free-running mode the count steps by one and wraps from 255 to 0.
- R4: In clear-on-match mode, the tick taken while the count equals the compare value loads 0. In the two non-PWM modes a compare write takes effect on the next tick.
- R5: In the non-PWM modes the output mode codes are 00 = disconnected, 01 = toggle on match, 10 = clear on match and 11 = set on match. With code 00, `wave_en` and `wave_out` are 0 and the level is kept. Any nonzero code sets `wave_en`.
- R6: In fast PWM with output code 10, `wave_out` is high while the visible count is at most the compare value. Code 11 gives the complement. Codes 00 and 01 disconnect the output (`wave_en` = 0).
- R7: In phase-correct mode the count runs 0 up to 255, then 254 down to 0, then 1 upward again. With output code 10 the output is high while counting up at a count no larger than the compare value, and while counting down at a count below it.
- R8: In phase-correct mode, from the first TOP onward, a compare value of 0 gives a constant low output and 255 a constant high output for code 10. Code 11 gives the complements.
- R9: In phase-correct mode the tick at BOTTOM sets the level to high if the compare value is nonzero and to low otherwise, with or without a match. For example, when the compare value moves from 255 to 0 the output falls at BOTTOM.
- R10: In both PWM modes a compare write is held in a buffer. It becomes active on the tick taken at count 255 (TOP).
- R11: `ovf_flag` pulses for one cycle just after the count reaches 0. In phase-correct mode this happens on the step down from 1; in the other modes it happens on the wrap from 255.
- R12: `cmp_flag` pulses for one cycle just after a tick taken while the count equals the active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 mode, 1 compare, 2 output mode, 3 prescale |
| cfg_wdata | input | 8 | Write data |
| count | output | 8 | Current counter value |
| wave_out | output | 1 | Compare waveform output |
| wave_en | output | 1 | High when the waveform should own the pin |
| ovf_flag | output | 1 | One-cycle overflow pulse |
| cmp_flag | output | 1 | One-cycle compare-match pulse |

## Verification
The count sequence is run under every mode code, including one reserved code, and under each prescale ratio. This separates the wrap, clear-at-compare and up/down sequences, and it shows a wrong division ratio as a wrong tick spacing. The waveform is compared against the visible count over whole periods in each PWM mode, with both output polarities and with mid-range and extreme compare values. Those runs separate the up-slope and down-slope thresholds and expose any glitch at 0 or 255. Two targeted patterns cover the buffered compare path. One writes a new compare value mid-period and checks that the old threshold still holds until TOP. The other moves the compare value from 255 to 0 in phase-correct mode, which isolates the forced transition at BOTTOM from an ordinary match.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  // Waveform-generation codes; codes 4..7 fall back to free-running.
  localparam logic [2:0] WG_NORMAL = 3'd0;
  localparam logic [2:0] WG_PHASE  = 3'd1;
  localparam logic [2:0] WG_CTC    = 3'd2;
  localparam logic [2:0] WG_FAST   = 3'd3;

  // Register addresses on the write port.
  localparam logic [1:0] AD_MODE = 2'd0;
  localparam logic [1:0] AD_CMP  = 2'd1;
  localparam logic [1:0] AD_COM  = 2'd2;
  localparam logic [1:0] AD_PSEL = 2'd3;

  typedef enum logic [1:0] {
    CO_OFF    = 2'b00,
    CO_TOGGLE = 2'b01,
    CO_CLEAR  = 2'b10,
    CO_SET    = 2'b11
  } co_mode_e;

  function automatic logic is_pwm(input logic [2:0] m);
    return (m == WG_PHASE) || (m == WG_FAST);
  endfunction

  function automatic logic ps_running(input logic [2:0] sel);
    return (sel >= 3'd1) && (sel <= 3'd5);
  endfunction

  // log2 of the division ratio for each running prescale code.
  function automatic int unsigned ps_shift(input logic [2:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [2:0]   mode,
  output co_mode_e     com,
  output logic [2:0]   psel,
  output logic [W-1:0] cmp_buf
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= WG_NORMAL;
      com     <= CO_OFF;
      psel    <= 3'd0;
      cmp_buf <= '0;
    end else if (we) begin
      case (addr)
        AD_MODE: mode    <= wdata[2:0];
        AD_CMP:  cmp_buf <= wdata;
        AD_COM:  com     <= co_mode_e'(wdata[1:0]);
        default: psel    <= wdata[2:0];
      endcase
    end
  end

endmodule

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler
  import pwmt_pkg::*;
#(
  parameter int PS_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       restart,
  output logic       tick
);

  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] mask;
  logic            run;

  always_comb begin
    run  = ps_running(sel);
    mask = PS_W'((64'd1 << ps_shift(sel)) - 64'd1);
    tick = run && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) div_q <= '0;
    else                           div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter
  import pwmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic [W-1:0] cmp_buf,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic [W-1:0] cmp_act,
  output logic [W-1:0] cmp_eff,
  output logic         ovf_evt,
  output logic         match_evt,
  output logic         bottom_evt
);

  localparam logic [W-1:0] CMAX = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_n;
  logic         down_n;
  logic         pwm;
  logic         at_top;
  logic         reload;

  always_comb begin
    pwm     = is_pwm(mode);
    at_top  = (cnt == CMAX);
    cmp_eff = pwm ? cmp_act : cmp_buf;
    reload  = tick && at_top && !(mode == WG_PHASE && down);
    cnt_n   = cnt + ONE;
    down_n  = 1'b0;
    case (mode)
      WG_PHASE: begin
        if (!down) begin
          if (at_top) begin
            cnt_n  = CMAX - ONE;
            down_n = 1'b1;
          end
        end else if (cnt == '0) begin
          cnt_n  = ONE;
          down_n = 1'b0;
        end else begin
          cnt_n  = cnt - ONE;
          down_n = 1'b1;
        end
      end
      WG_CTC: begin
        if (cnt == cmp_eff) cnt_n = '0;
      end
      default: ;
    endcase
    match_evt  = tick && (cnt == cmp_eff);
    bottom_evt = tick && (mode == WG_PHASE) && down && (cnt == '0);
    ovf_evt    = tick && ((mode == WG_PHASE) ? (down && cnt == ONE) : at_top);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      down    <= 1'b0;
      cmp_act <= '0;
    end else begin
      if (tick) begin
        cnt  <= cnt_n;
        down <= down_n;
      end else if (mode != WG_PHASE) begin
        down <= 1'b0;
      end
      if (!pwm || reload) cmp_act <= cmp_buf;
    end
  end

endmodule

// File: rtl/pwmt_wave.sv
module pwmt_wave
  import pwmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  co_mode_e     com,
  input  logic [W-1:0] cnt,
  input  logic         down,
  input  logic [W-1:0] cmp_eff,
  input  logic         match_evt,
  input  logic         bottom_evt,
  output logic         wave_out,
  output logic         wave_en
);

  localparam logic [W-1:0] CMAX = '1;

  logic lvl;
  logic lvl_n;
  logic pwm;

  always_comb begin
    pwm   = is_pwm(mode);
    lvl_n = lvl;
    case (mode)
      WG_FAST: begin
        // set when wrapping to BOTTOM, clear on the match tick
        if (cnt == CMAX)    lvl_n = 1'b1;
        else if (match_evt) lvl_n = 1'b0;
      end
      WG_PHASE: begin
        if (bottom_evt)              lvl_n = (cmp_eff != '0);
        else if (match_evt && !down) lvl_n = (cmp_eff == CMAX);
        else if (match_evt && down)  lvl_n = 1'b1;
      end
      default: begin
        if (match_evt) begin
          case (com)
            CO_TOGGLE: lvl_n = ~lvl;
            CO_CLEAR:  lvl_n = 1'b0;
            CO_SET:    lvl_n = 1'b1;
            default:   lvl_n = lvl;
          endcase
        end
      end
    endcase
    wave_en  = pwm ? com[1] : (com != CO_OFF);
    wave_out = wave_en && ((pwm && com == CO_SET) ? ~lvl : lvl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    lvl <= 1'b0;
    else if (tick) lvl <= lvl_n;
  end

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PS_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0] count,
  output logic             wave_out,
  output logic             wave_en,
  output logic             ovf_flag,
  output logic             cmp_flag
);

  logic [2:0]       mode_q;
  co_mode_e         com_q;
  logic [2:0]       psel_q;
  logic [CNT_W-1:0] cmp_buf;
  logic [CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0] cmp_eff;
  logic             tick;
  logic             down;
  logic             ps_restart;
  logic             ovf_evt;
  logic             match_evt;
  logic             bottom_evt;

  assign ps_restart = cfg_we && (cfg_addr == AD_PSEL);

  pwmt_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode(mode_q), .com(com_q), .psel(psel_q), .cmp_buf(cmp_buf)
  );

  pwmt_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .sel(psel_q), .restart(ps_restart), .tick(tick)
  );

  pwmt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .cmp_buf(cmp_buf),
    .cnt(count), .down(down), .cmp_act(cmp_act), .cmp_eff(cmp_eff),
    .ovf_evt(ovf_evt), .match_evt(match_evt), .bottom_evt(bottom_evt)
  );

  pwmt_wave #(.W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .com(com_q),
    .cnt(count), .down(down), .cmp_eff(cmp_eff), .match_evt(match_evt),
    .bottom_evt(bottom_evt), .wave_out(wave_out), .wave_en(wave_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      ovf_flag <= ovf_evt;
      cmp_flag <= match_evt;
    end
  end

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
  import pwmt_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [2:0]   mode,
  input logic [2:0]   psel,
  input logic [1:0]   com,
  input logic [W-1:0] count,
  input logic         down,
  input logic [W-1:0] cmp_act,
  input logic [W-1:0] cmp_eff,
  input logic         wave_en,
  input logic         wave_out,
  input logic         ovf_flag,
  input logic         cmp_flag
);

  localparam logic [W-1:0] CMAX = '1;

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (psel == 3'd0) |=> $stable(count)); // R2

  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WG_CTC && tick && count == cmp_eff) |=> (count == '0)); // R4

  AST_WAVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (com == 2'b00) |-> (!wave_en && !wave_out)); // R5

  AST_PC_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WG_PHASE && tick && count == CMAX && !down) |=> (count == CMAX - 1'b1)); // R7

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm(mode) && !(tick && count == CMAX)) |=> $stable(cmp_act)); // R10

  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> (count == '0)); // R11

  AST_CMP_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_flag |-> ($past(count) == $past(cmp_eff))); // R12

endmodule

bind pwm_timer8 pwmt_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q), .psel(psel_q),
  .com(com_q), .count(count), .down(down), .cmp_act(cmp_act), .cmp_eff(cmp_eff),
  .wave_en(wave_en), .wave_out(wave_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
);

// File: tb/pwm_timer8_test.sv
module pwm_timer8_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [7:0] count;
  logic       wave_out, wave_en, ovf_flag, cmp_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_timer8 uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .count(count), .wave_out(wave_out),
    .wave_en(wave_en), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (count %0d)", req, what, act, exp, count);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // compare written in free-running mode so it is active at once
  task automatic setup(input logic [2:0] m, input logic [7:0] c,
                       input logic [1:0] co, input logic [2:0] ps);
    wr(2'd0, 8'd0);
    wr(2'd1, c);
    wr(2'd2, {6'd0, co});
    wr(2'd0, {5'd0, m});
    wr(2'd3, {5'd0, ps});
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(count == 0, "R1", "count after reset", count, 0);
    check(!wave_out && !wave_en, "R1", "wave after reset", {wave_en, wave_out}, 0);
    check(!ovf_flag && !cmp_flag, "R1", "flags after reset", {ovf_flag, cmp_flag}, 0);
    skip(20);
    check(count == 0, "R1", "counter stopped by default", count, 0);
  endtask

  task automatic measure(input string what, input int exp);
    int c0;
    int n;
    c0 = count; n = 0;
    while (count == c0 && n < 3000) begin @(negedge clk); n++; end
    c0 = count; n = 0;
    do begin @(negedge clk); n++; end while (count == c0 && n < 3000);
    check(n == exp, "R2", what, n, exp);
  endtask

  task automatic t_prescale();
    int c0;
    do_reset();
    setup(3'd0, 8'd0, 2'b00, 3'd2);
    measure("tick spacing /8", 8);
    wr(2'd3, 8'd3); measure("tick spacing /64", 64);
    wr(2'd3, 8'd4); measure("tick spacing /256", 256);
    wr(2'd3, 8'd5); measure("tick spacing /1024", 1024);
    wr(2'd3, 8'd1); measure("tick spacing /1", 1);
    wr(2'd3, 8'd6); c0 = count; skip(100);
    check(count == c0, "R2", "code 6 stops count", count, c0);
    wr(2'd3, 8'd0); c0 = count; skip(100);
    check(count == c0, "R2", "code 0 stops count", count, c0);
  endtask

  task automatic run_free(input int n, input string what);
    int prev;
    prev = count;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(count == ((prev + 1) & 255), "R3", what, count, (prev + 1) & 255);
      check(ovf_flag == (prev == 255), "R11", "ovf at wrap", ovf_flag, prev == 255);
      check(cmp_flag == (prev == 0), "R12", "cmp at count 0", cmp_flag, prev == 0);
      prev = count;
    end
  endtask

  task automatic t_normal();
    do_reset();
    setup(3'd0, 8'd0, 2'b00, 3'd1);
    run_free(600, "free-running step");
    wr(2'd0, 8'd5);
    run_free(300, "reserved code 5 step");
  endtask

  task automatic t_ctc();
    int prev;
    int pw;
    int mx;
    do_reset();
    setup(3'd2, 8'd20, 2'b01, 3'd1);
    prev = count; pw = wave_out;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      check(count == ((prev == 20) ? 0 : prev + 1), "R4", "clear at compare", count,
            (prev == 20) ? 0 : prev + 1);
      check(wave_out == (pw ^ (prev == 20)), "R5", "toggle on match", wave_out, pw ^ (prev == 20));
      check(cmp_flag == (prev == 20), "R12", "cmp pulse", cmp_flag, prev == 20);
      check(wave_en == 1, "R5", "wave_en toggle", wave_en, 1);
      prev = count; pw = wave_out;
    end
    while (count != 10) @(negedge clk);
    wr(2'd1, 8'd40);
    mx = 0;
    while (count != 0) begin
      if (count > mx) mx = count;
      @(negedge clk);
    end
    check(mx == 40, "R4", "new compare used at once", mx, 40);
  endtask

  task automatic t_ctc_setclr();
    do_reset();
    setup(3'd2, 8'd20, 2'b11, 3'd1);
    skip(30);
    check(wave_out == 1 && wave_en == 1, "R5", "set on match", wave_out, 1);
    wr(2'd2, 8'd2); skip(30);
    check(wave_out == 0 && wave_en == 1, "R5", "clear on match", wave_out, 0);
    wr(2'd2, 8'd3); skip(30);
    wr(2'd2, 8'd0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(!wave_out && !wave_en, "R5", "disconnected", {wave_en, wave_out}, 0);
    end
    wr(2'd2, 8'd2);
    check(wave_out == 1, "R5", "level kept while disconnected", wave_out, 1);
  endtask

  task automatic t_fast();
    do_reset();
    setup(3'd3, 8'd100, 2'b10, 3'd1);
    skip(300);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      check(wave_out == (count <= 100), "R6", "fast non-inverted", wave_out, count <= 100);
    end
    wr(2'd2, 8'd3);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      check(wave_out == (count > 100), "R6", "fast inverted", wave_out, count > 100);
    end
    wr(2'd2, 8'd1);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      check(!wave_en && !wave_out, "R6", "code 01 disconnected", {wave_en, wave_out}, 0);
    end
  endtask

  task automatic t_fast_buffer();
    int prev;
    int eff;
    do_reset();
    setup(3'd3, 8'd100, 2'b10, 3'd1);
    skip(300);
    while (count != 50) @(negedge clk);
    wr(2'd1, 8'd200);
    prev = count; eff = 100;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (prev == 255 && count == 0) eff = 200;
      check(wave_out == (count <= eff), "R10", "buffered compare", wave_out, count <= eff);
      prev = count;
    end
  endtask

  task automatic t_pc();
    int prev;
    bit up;
    int exp;
    do_reset();
    setup(3'd1, 8'd100, 2'b10, 3'd1);
    prev = count; up = 1'b1;
    for (int i = 0; i < 1600; i++) begin
      @(negedge clk);
      if (prev == 255) up = 1'b0;
      else if (prev == 0) up = 1'b1;
      exp = up ? prev + 1 : prev - 1;
      check(count == exp, "R7", "dual-slope sequence", count, exp);
      if (i > 520)
        check(wave_out == (up ? (count <= 100) : (count < 100)), "R7", "phase-correct level",
              wave_out, up ? (count <= 100) : (count < 100));
      check(ovf_flag == (prev == 1 && count == 0), "R11", "ovf at BOTTOM", ovf_flag,
            prev == 1 && count == 0);
      check(cmp_flag == (prev == 100), "R12", "cmp pulse both slopes", cmp_flag, prev == 100);
      prev = count;
    end
  endtask

  task automatic pc_level(input logic [7:0] c, input logic [1:0] co, input int exp,
                          input string what);
    do_reset();
    setup(3'd1, c, co, 3'd1);
    skip(600);
    for (int i = 0; i < 520; i++) begin
      @(negedge clk);
      check(wave_out == exp, "R8", what, wave_out, exp);
    end
  endtask

  task automatic t_pc_ext();
    pc_level(8'd0,   2'b10, 0, "compare 0 low");
    pc_level(8'd0,   2'b11, 1, "compare 0 inverted high");
    pc_level(8'd255, 2'b10, 1, "compare 255 high");
    pc_level(8'd255, 2'b11, 0, "compare 255 inverted low");
  endtask

  task automatic t_pc_bottom();
    int prev;
    int st;
    do_reset();
    setup(3'd1, 8'd255, 2'b10, 3'd1);
    skip(600);
    while (count != 100) @(negedge clk);
    wr(2'd1, 8'd0);
    prev = count; st = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (st == 0 && prev == 255 && count == 254) st = 1;
      else if (st == 1 && prev == 0 && count == 1) st = 2;
      check(wave_out == (st < 2), "R9", "forced change at BOTTOM", wave_out, st < 2);
      prev = count;
    end
    check(st == 2, "R9", "BOTTOM reached after TOP", st, 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_prescale();
    t_normal();
    t_ctc();
    t_ctc_setclr();
    t_fast();
    t_fast_buffer();
    t_pc();
    t_pc_ext();
    t_pc_bottom();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule